// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the column address of every beat of one read or write burst on a double-data-rate memory. It runs on the beat clock, so each clock cycle carries one beat, which is half a cycle of the memory clock. A 4-bit mode word chooses the burst length and the burst type. The block keeps that word until it is loaded again. A start strobe with an 8-bit start column launches a burst. The block then steps through the columns in the order that the burst type sets and marks the final beat of each fixed-length burst.

A full-page burst walks the whole 256-column page in ascending order and wraps round. It runs until the stop input ends it. A new start strobe cuts any running burst short, in the way that a read cuts off a write, and the new burst begins on the next cycle. The block refuses a mode that the memory cannot execute: a reserved length code, a full page in interleave mode, or a full page that starts on an odd column. For these it issues no beats and raises a flag instead.

Top module: `ddr_burst_colgen`

## Requirements
- R1: While reset is asserted and after its release, beat_valid, beat_last and mode_illegal are low and col is zero. The stored mode word resets to 4'b0001, which is a 2-beat sequential burst.
- R2: The mode word uses bits [2:0] as the length code (3'b001 = 2 beats, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page) and bit 3 as the type (0 = sequential, 1 = interleave). mode_load stores the word only when no burst is active and start is low; otherwise mode_load is ignored.
- R3: After a legal start, beat_valid is high from the next cycle. The first column equals start_col, and one beat follows per cycle. col reads zero whenever beat_valid is low.
- R4: In a sequential burst of N = 2, 4 or 8 beats, beat i keeps the bits of start_col above log2(N), and its low log2(N) bits equal (start_col + i) mod N.
- R5: In an interleaved burst of N beats, beat i keeps the upper bits of start_col, and its low log2(N) bits equal start_col XOR i.
- R6: beat_last is high on beat N-1 of a fixed-length burst. On the cycle after that, beat_valid is low unless a new start was taken.
- R7: A full-page sequential burst issues (start_col + i) mod 256 with no end of its own, and beat_last stays low throughout.
- R8: When stop is high with no start, the beat on display at that clock edge is the final one, and beat_valid is low on the next cycle. stop has no effect while no burst is active.
- R9: A start during an active burst drops the remaining beats. The next cycle shows the first column of the new burst. start takes priority over stop.
- R10: A start with a reserved length code, with full page in interleave mode, or with full page at an odd start_col issues no beat. mode_illegal is high from the next cycle until the next start is evaluated, and a legal start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; one beat per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Store mode_word when idle |
| mode_word | input | 4 | Bits [2:0] length code, bit 3 burst type |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 8 | Column of the first beat |
| stop | input | 1 | End the running burst after the current beat |
| col | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is on col this cycle |
| beat_last | output | 1 | Current beat ends a fixed-length burst |
| mode_illegal | output | 1 | Last start request was refused |

## Verification
Some rules are checked by the assertions on every clock cycle:
- a burst ends after its last beat or after stop;
- a restart shows the new start column on the next cycle;
- consecutive beats of a fixed burst stay inside one aligned 8-column block;
- no beat is issued while the illegal flag is high;
- the stored mode cannot change while a burst runs.

Other behaviours can be shown only by the bench's scenarios:
- the exact order of columns for each length and type;
- the 256-column wrap of a full page;
- that a mode load made during a burst has no effect on the next burst;
- that the illegal flag clears again.

// File: rtl/ddr_bcg_pkg.sv
package ddr_bcg_pkg;

    // Length codes carried in bits [2:0] of the mode word
    localparam logic [2:0] LEN_BL2  = 3'b001;
    localparam logic [2:0] LEN_BL4  = 3'b010;
    localparam logic [2:0] LEN_BL8  = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    // Burst ordering selected by bit 3 of the mode word
    typedef enum logic {
        ORD_SEQ  = 1'b0,
        ORD_INTL = 1'b1
    } burst_ord_e;

    // Decoded view of one mode word
    typedef struct packed {
        logic       legal;  // code usable with this ordering
        logic       page;   // full-page burst
        burst_ord_e ord;    // beat ordering
        logic [1:0] lg;     // log2 of fixed length (1..3)
    } mode_dec_t;

endpackage

// File: rtl/ddr_bcg_mode_dec.sv
module ddr_bcg_mode_dec
    import ddr_bcg_pkg::*;
(
    input  logic [3:0] word,
    output mode_dec_t  dec
);

    always_comb begin
        dec.ord   = burst_ord_e'(word[3]);
        dec.page  = 1'b0;
        dec.legal = 1'b1;
        dec.lg    = 2'd1;
        unique case (word[2:0])
            LEN_BL2:  dec.lg = 2'd1;
            LEN_BL4:  dec.lg = 2'd2;
            LEN_BL8:  dec.lg = 2'd3;
            LEN_PAGE: begin
                dec.page  = 1'b1;
                dec.lg    = 2'd3;
                // full page exists only in ascending order
                dec.legal = (word[3] == 1'b0);
            end
            default:  dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/ddr_bcg_addr_map.sv
module ddr_bcg_addr_map
    import ddr_bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  mode_dec_t        mode,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] intl_col;
    logic [COL_W-1:0] pick;

    // Bits that move within the burst; the rest stay as in base
    for (genvar b = 0; b < COL_W; b++) begin : g_mask
        if (b < 3) begin : g_low
            assign wrap_mask[b] = mode.page | (mode.lg > 2'(b));
        end else begin : g_high
            assign wrap_mask[b] = mode.page;
        end
    end

    assign seq_col  = base + idx;
    assign intl_col = base ^ idx;
    assign pick     = (mode.ord == ORD_INTL) ? intl_col : seq_col;
    assign col      = (pick & wrap_mask) | (base & ~wrap_mask);

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
    import ddr_bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [3:0]       mode_word,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             mode_illegal
);

    localparam logic [3:0] MODE_RST = {1'b0, LEN_BL2};

    typedef struct packed {
        logic             busy;
        logic             ill;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] base;
        logic [3:0]       mode;
        mode_dec_t        bmode;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    mode_dec_t        live_dec;
    logic [COL_W-1:0] map_col;
    logic [COL_W-1:0] last_idx;
    logic             at_last;
    logic             odd_page;
    logic             start_ok;

    ddr_bcg_mode_dec u_live_dec (
        .word (st_q.mode),
        .dec  (live_dec)
    );

    ddr_bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base (st_q.base),
        .idx  (st_q.idx),
        .mode (st_q.bmode),
        .col  (map_col)
    );

    always_comb begin
        last_idx = '0;
        unique case (st_q.bmode.lg)
            2'd1:    last_idx[2:0] = 3'd1;
            2'd2:    last_idx[2:0] = 3'd3;
            default: last_idx[2:0] = 3'd7;
        endcase
    end

    assign at_last  = st_q.busy && !st_q.bmode.page && (st_q.idx == last_idx);
    assign odd_page = live_dec.page && start_col[0];
    assign start_ok = live_dec.legal && !odd_page;

    always_comb begin
        st_d = st_q;
        if (start) begin
            if (start_ok) begin
                st_d.busy  = 1'b1;
                st_d.ill   = 1'b0;
                st_d.idx   = '0;
                st_d.base  = start_col;
                st_d.bmode = live_dec;
            end else begin
                st_d.busy  = 1'b0;
                st_d.ill   = 1'b1;
            end
        end else if (st_q.busy) begin
            if (stop || at_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx  = st_q.idx + 1'b1;
            end
        end else if (mode_load) begin
            st_d.mode = mode_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, ill: 1'b0, idx: '0, base: '0,
                      mode: MODE_RST, bmode: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign col          = st_q.busy ? map_col : '0;
    assign beat_valid   = st_q.busy;
    assign beat_last    = at_last;
    assign mode_illegal = st_q.ill;

    // ---------------- assertions ----------------
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> (st_q.mode == $past(st_q.mode)))
        else $error("R2: mode changed during a burst");

    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_valid)
        else $error("R6: burst continued past last beat");

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && stop && !start) |=> !beat_valid)
        else $error("R8: burst continued after stop");

    a_r9_restart_col: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_ok) |=> (beat_valid && col == $past(start_col)))
        else $error("R9: first column wrong after start");

    a_r4_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !st_q.bmode.page && $past(beat_valid) && !$past(start))
            |-> ((col >> 3) == ($past(col) >> 3)))
        else $error("R4: fixed burst left its aligned block");

    a_r10_odd_page: assert property (@(posedge clk) disable iff (!rst_n)
        (start && live_dec.page && start_col[0]) |=> (!beat_valid && mode_illegal))
        else $error("R10: odd full-page start accepted");

    a_r10_no_beat_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_valid && mode_illegal))
        else $error("R10: beat issued while flagged");

    a_r10_legal_running: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.bmode.legal)
        else $error("R10: illegal mode running");

endmodule

// File: tb/ddr_burst_colgen_tb_top.sv
module ddr_burst_colgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_load;
    logic [3:0] mode_word;
    logic       start;
    logic [7:0] start_col;
    logic       stop;
    logic [7:0] col;
    logic       beat_valid;
    logic       beat_last;
    logic       mode_illegal;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ddr_burst_colgen dut_i (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .stop(stop), .col(col),
        .beat_valid(beat_valid), .beat_last(beat_last), .mode_illegal(mode_illegal)
    );

    // {mode word, start column}
    localparam int NV = 14;
    localparam logic [11:0] VEC [NV] = '{
        {4'h1, 8'h05}, {4'h9, 8'h05}, {4'h2, 8'h05}, {4'hA, 8'h05},
        {4'h3, 8'hFD}, {4'hB, 8'h3A}, {4'h0, 8'h10}, {4'h2, 8'h82},
        {4'h4, 8'h10}, {4'h5, 8'h10}, {4'h6, 8'h10}, {4'hF, 8'h20},
        {4'h7, 8'h11}, {4'hB, 8'hC4}
    };

    function automatic int exp_len(logic [3:0] m, logic [7:0] c);
        case (m[2:0])
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return (m[3] || c[0]) ? 0 : 256;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(logic [3:0] m, logic [7:0] c, int i);
        int n;
        int msk;
        n   = exp_len(m, c);
        msk = n - 1;
        if (m[3]) return 8'((c & ~msk) | ((c ^ i) & msk));
        return 8'((c & ~msk) | ((c + i) & msk));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_mode(logic [3:0] m);
        mode_load = 1'b1;
        mode_word = m;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic start_burst(logic [7:0] c);
        start     = 1'b1;
        start_col = c;
        @(negedge clk);
        start     = 1'b0;
    endtask

    // Called at the sampling point of beat 0
    task automatic check_beats(logic [3:0] m, logic [7:0] c, string tag);
        int n;
        n = exp_len(m, c);
        if (n == 0) begin
            check("R10 no beat", beat_valid, 0);
            check("R10 flag", mode_illegal, 1);
        end else begin
            check("R10 flag clear", mode_illegal, 0);
            for (int i = 0; i < n; i++) begin
                check(tag, beat_valid, 1);
                check(tag, col, exp_col(m, c, i));
                check("R6 last", beat_last, (i == n - 1) ? 1 : 0);
                @(negedge clk);
            end
            check("R6 end", beat_valid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_load = 1'b0; mode_word = 4'h0;
        start = 1'b0; start_col = 8'h00; stop = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", beat_valid, 0);
        check("R1 last", beat_last, 0);
        check("R1 illegal", mode_illegal, 0);
        check("R1 col", col, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after", beat_valid, 0);
        // R1 default mode is 2-beat sequential; R3 first column
        start_burst(8'h03);
        check("R3 first col", col, 8'h03);
        check_beats(4'h1, 8'h03, "R1 default");

        // table walk: R4, R5, R10
        for (int v = 0; v < NV; v++) begin
            load_mode(VEC[v][11:8]);
            start_burst(VEC[v][7:0]);
            check_beats(VEC[v][11:8], VEC[v][7:0], VEC[v][11] ? "R5 intl" : "R4 seq");
            @(negedge clk);
        end

        // R8 stop while idle has no effect
        stop = 1'b1;
        repeat (2) @(negedge clk);
        stop = 1'b0;
        check("R8 idle stop", beat_valid, 0);

        // R7 full page wraps, no last
        load_mode(4'h7);
        start_burst(8'hFE);
        for (int i = 0; i < 260; i++) begin
            check("R7 valid", beat_valid, 1);
            check("R7 col", col, 8'((8'hFE + i) & 8'hFF));
            check("R7 no last", beat_last, 0);
            @(negedge clk);
        end
        check("R7 col 260", col, 8'h02);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R8 page stop", beat_valid, 0);

        // R8 stop cuts a fixed burst
        load_mode(4'h3);
        start_burst(8'h40);
        @(negedge clk);
        check("R8 beat1", col, 8'h41);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R8 fixed stop", beat_valid, 0);

        // R9 restart mid burst, start beats stop
        start_burst(8'h10);
        repeat (3) @(negedge clk);
        check("R9 before", col, 8'h13);
        start = 1'b1; start_col = 8'h21; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check_beats(4'h3, 8'h21, "R9 restart");

        // R2 mode load during burst ignored
        start_burst(8'h00);
        mode_load = 1'b1; mode_word = 4'h1;
        check("R2 beat0", col, 8'h00);
        @(negedge clk);
        mode_load = 1'b0;
        for (int i = 1; i < 8; i++) begin
            check("R2 busy col", col, 8'(i));
            @(negedge clk);
        end
        check("R2 ended", beat_valid, 0);
        start_burst(8'h08);
        check_beats(4'h3, 8'h08, "R2 mode kept");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule